// File: doc/BRIEF.md
# Capture Channel Polarity and Enable Control

This block is the control slice of one capture/compare channel of a timer. It holds four configuration bits: a polarity bit, a complementary polarity bit, a channel enable and a complementary enable. All four are written through a simple write port. When the channel works as an input, the block samples an already filtered input signal and detects its edges. The two polarity bits together select which edges count as trigger or capture events. The same code also gives a level for gated operation, inverted or not. A trigger event latches the free-running counter value into a capture register, but only when the channel enable is set.

When the channel works as an output, each polarity bit decides whether the matching reference waveform leaves the block active high or active low. Both polarity bits can be preloaded. With preload control on, writes land in a shadow copy, and the active bits pick that copy up only on a commutation pulse. A lock level of 2 or above freezes the polarity bits against writes. For the complementary bit the freeze applies only while the channel is an output.

Top module: `capchan_ctl`

## Requirements
- R1: A synchronous reset clears both polarity bits, both enables, the capture register and all registered outputs to 0.
- R2: With polarity code {complementary polarity, polarity} = 2'b00, a rising input edge gives a one-cycle `trig_o` pulse on the next clock. A falling edge gives none. `gate_o` equals the input sampled one cycle earlier.
- R3: With code 2'b01, only a falling input edge gives a `trig_o` pulse, and `gate_o` is the inverted input sampled one cycle earlier.
- R4: With code 2'b11, both rising and falling edges give a `trig_o` pulse, and `gate_o` is not inverted.
- R5: The reserved code 2'b10 behaves exactly like 2'b00.
- R6: A trigger event, with the channel enable at 1 and `is_output` at 0, pulses `cap_stb_o` and loads `cnt_in` into `cap_val_o`. Otherwise `cap_val_o` keeps its value and `cap_stb_o` stays 0.
- R7: `oc_o` is `oc_ref` XOR the polarity bit, and `ocn_o` is `ocn_ref` XOR the complementary polarity bit, both registered one cycle.
- R8: With `preload_on` at 0, a permitted write updates the active polarity bits at that clock edge. A write always updates both enables.
- R9: With `preload_on` at 1, writes do not change the active polarity bits. A `commute` pulse copies the shadow copies into them.
- R10: A `commute` pulse in the same cycle as a write transfers the shadow value held before that write. The newly written value reaches the active bits at the next `commute`.
- R11: With `lock_lvl` >= 2, writes to the polarity bit are ignored. Writes to the complementary polarity bit are ignored only while `is_output` is 1.
- R12: The first sampled input after reset never produces a `trig_o` pulse, whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration bits |
| wr_pol | input | 1 | Write value, polarity bit |
| wr_npol | input | 1 | Write value, complementary polarity bit |
| wr_oen | input | 1 | Write value, channel enable |
| wr_noen | input | 1 | Write value, complementary enable |
| lock_lvl | input | LOCK_W | Protection level; 2 or above freezes polarity |
| is_output | input | 1 | 1 when the channel is configured as an output |
| preload_on | input | 1 | Route polarity writes through the shadow copy |
| commute | input | 1 | Commutation pulse, loads shadow into active bits |
| sig_in | input | 1 | Filtered, synchronous channel input |
| cnt_in | input | CNT_W | Counter value to capture |
| oc_ref | input | 1 | Reference waveform, main output |
| ocn_ref | input | 1 | Reference waveform, complementary output |
| trig_o | output | 1 | Selected-edge pulse |
| gate_o | output | 1 | Polarity-conditioned level for gated operation |
| cap_stb_o | output | 1 | Capture strobe |
| cap_val_o | output | CNT_W | Captured counter value |
| oc_o | output | 1 | Polarity-adjusted main output |
| ocn_o | output | 1 | Polarity-adjusted complementary output |
| pol_o | output | 1 | Active polarity bit |
| npol_o | output | 1 | Active complementary polarity bit |
| oen_o | output | 1 | Channel enable |
| noen_o | output | 1 | Complementary enable |

## Verification
Two functions can act in the same cycle. A register write and a commutation pulse can both arrive at one clock edge while preload is on. An enable write can also coincide with an input edge. The bench drives the write and the commutation together, then checks that the active polarity bits take the previous shadow value and change to the new value only at the following commutation. A scoreboard model predicts each cycle's trigger, capture and polarity outputs from the configuration held before the edge. It therefore also judges captures that land in the same cycle as an enable change.

// File: rtl/capchan_pkg.sv
`timescale 1ns/1ps
package capchan_pkg;

  // Polarity code {complementary polarity, polarity}
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RSVD = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_code_e;

  localparam int POL_LANES = 2;   // lane 0: polarity, lane 1: complementary

  function automatic logic edge_hit(edge_code_e c, logic r, logic f);
    logic hit;
    case (c)
      EDGE_FALL: hit = f;
      EDGE_BOTH: hit = r | f;
      default:   hit = r;      // rising and the reserved code
    endcase
    return hit;
  endfunction

  function automatic logic gate_inv(edge_code_e c);
    return (c == EDGE_FALL);
  endfunction

endpackage

// File: rtl/capchan_regs.sv
`timescale 1ns/1ps
module capchan_regs #(
  parameter int LOCK_W   = 2,
  parameter int LOCK_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_pol_bits,   // [0] polarity, [1] complementary
  input  logic [1:0]        wr_en_bits,    // [0] enable, [1] complementary
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic              is_output,
  input  logic              preload_on,
  input  logic              commute,
  output logic [1:0]        pol_act,
  output logic [1:0]        en_act
);
  import capchan_pkg::*;

  logic locked;
  assign locked = (lock_lvl >= LOCK_W'(LOCK_MIN));

  for (genvar g = 0; g < POL_LANES; g++) begin : g_lane
    logic blk, wr_ok, sh_q, act_q;

    if (g == 0) begin : g_main
      assign blk = locked;
    end else begin : g_comp
      assign blk = locked & is_output;
    end

    assign wr_ok = wr_en & ~blk;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q  <= 1'b0;
        act_q <= 1'b0;
      end else begin
        if (preload_on && commute)
          act_q <= sh_q;                 // previous shadow value
        else if (!preload_on && wr_ok)
          act_q <= wr_pol_bits[g];
        if (wr_ok)
          sh_q <= wr_pol_bits[g];
      end
    end

    assign pol_act[g] = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        en_act <= 2'b00;
    else if (wr_en) en_act <= wr_en_bits;
  end

endmodule

// File: rtl/capchan_edge.sv
`timescale 1ns/1ps
module capchan_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev_q, vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= din;
      vld_q  <= 1'b1;
    end
  end

  assign rise = vld_q &  din & ~prev_q;
  assign fall = vld_q & ~din &  prev_q;

endmodule

// File: rtl/capchan_sel.sv
`timescale 1ns/1ps
module capchan_sel
  import capchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  edge_code_e       code,
  input  logic             cap_en,
  input  logic             is_output,
  input  logic             rise,
  input  logic             fall,
  input  logic             din,
  input  logic [CNT_W-1:0] cnt,
  input  logic             oc_ref,
  input  logic             ocn_ref,
  input  logic             pol,
  input  logic             npol,
  output logic             trig_o,
  output logic             gate_o,
  output logic             cap_stb_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             oc_o,
  output logic             ocn_o
);
  logic trig_c, take_c;

  assign trig_c = edge_hit(code, rise, fall);
  assign take_c = trig_c & cap_en & ~is_output;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o    <= 1'b0;
      gate_o    <= 1'b0;
      cap_stb_o <= 1'b0;
      cap_val_o <= '0;
      oc_o      <= 1'b0;
      ocn_o     <= 1'b0;
    end else begin
      trig_o    <= trig_c;
      gate_o    <= din ^ gate_inv(code);
      cap_stb_o <= take_c;
      if (take_c) cap_val_o <= cnt;
      oc_o      <= oc_ref  ^ pol;
      ocn_o     <= ocn_ref ^ npol;
    end
  end

endmodule

// File: rtl/capchan_ctl.sv
`timescale 1ns/1ps
module capchan_ctl
  import capchan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOCK_W   = 2,
  parameter int LOCK_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_pol,
  input  logic              wr_npol,
  input  logic              wr_oen,
  input  logic              wr_noen,
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic              is_output,
  input  logic              preload_on,
  input  logic              commute,
  input  logic              sig_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              oc_ref,
  input  logic              ocn_ref,
  output logic              trig_o,
  output logic              gate_o,
  output logic              cap_stb_o,
  output logic [CNT_W-1:0]  cap_val_o,
  output logic              oc_o,
  output logic              ocn_o,
  output logic              pol_o,
  output logic              npol_o,
  output logic              oen_o,
  output logic              noen_o
);
  logic [1:0] pol_act, en_act;
  logic       rise, fall;
  edge_code_e code;

  capchan_regs #(.LOCK_W(LOCK_W), .LOCK_MIN(LOCK_MIN)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_pol_bits({wr_npol, wr_pol}),
    .wr_en_bits ({wr_noen, wr_oen}),
    .lock_lvl   (lock_lvl),
    .is_output  (is_output),
    .preload_on (preload_on),
    .commute    (commute),
    .pol_act    (pol_act),
    .en_act     (en_act)
  );

  capchan_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (sig_in),
    .rise (rise),
    .fall (fall)
  );

  assign code = edge_code_e'({pol_act[1], pol_act[0]});

  capchan_sel #(.CNT_W(CNT_W)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .code      (code),
    .cap_en    (en_act[0]),
    .is_output (is_output),
    .rise      (rise),
    .fall      (fall),
    .din       (sig_in),
    .cnt       (cnt_in),
    .oc_ref    (oc_ref),
    .ocn_ref   (ocn_ref),
    .pol       (pol_act[0]),
    .npol      (pol_act[1]),
    .trig_o    (trig_o),
    .gate_o    (gate_o),
    .cap_stb_o (cap_stb_o),
    .cap_val_o (cap_val_o),
    .oc_o      (oc_o),
    .ocn_o     (ocn_o)
  );

  assign pol_o  = pol_act[0];
  assign npol_o = pol_act[1];
  assign oen_o  = en_act[0];
  assign noen_o = en_act[1];

endmodule

// File: rtl/capchan_ctl_chk.sv
`timescale 1ns/1ps
module capchan_ctl_chk #(
  parameter int CNT_W    = 16,
  parameter int LOCK_W   = 2,
  parameter int LOCK_MIN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sig_in,
  input logic              trig_o,
  input logic              cap_stb_o,
  input logic [CNT_W-1:0]  cap_val_o,
  input logic              oen_o,
  input logic              is_output,
  input logic              pol_o,
  input logic              npol_o,
  input logic [LOCK_W-1:0] lock_lvl,
  input logic              preload_on,
  input logic              commute,
  input logic              oc_ref,
  input logic              oc_o
);

  // R2: a trigger pulse needs an input change between the two prior samples
  a_r2_trig_on_change: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> ($past(sig_in) != $past(sig_in, 2)));

  // R12: no trigger from the first sample after reset
  a_r12_no_false_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rst, 2)) |-> !trig_o);

  // R6: capture only with enable set in input mode, on a trigger
  a_r6_cap_needs_enable: assert property (@(posedge clk) disable iff (rst)
    cap_stb_o |-> ($past(oen_o) && !$past(is_output) && trig_o));

  // R6: captured value moves only with a strobe
  a_r6_capval_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cap_val_o)) |-> cap_stb_o);

  // R7: output polarity applied one cycle later
  a_r7_oc_polarity: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (oc_o == ($past(oc_ref) ^ $past(pol_o))));

  // R9: preload on, no commutation -> active polarity bits hold
  a_r9_preload_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(preload_on) && !$past(commute))
      |-> ($stable(pol_o) && $stable(npol_o)));

  // R11: lock freezes the polarity bit outside commutation
  a_r11_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(lock_lvl) >= LOCK_W'(LOCK_MIN))
      && !$past(preload_on && commute)) |-> $stable(pol_o));

endmodule

bind capchan_ctl capchan_ctl_chk #(
  .CNT_W(CNT_W), .LOCK_W(LOCK_W), .LOCK_MIN(LOCK_MIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sig_in     (sig_in),
  .trig_o     (trig_o),
  .cap_stb_o  (cap_stb_o),
  .cap_val_o  (cap_val_o),
  .oen_o      (oen_o),
  .is_output  (is_output),
  .pol_o      (pol_o),
  .npol_o     (npol_o),
  .lock_lvl   (lock_lvl),
  .preload_on (preload_on),
  .commute    (commute),
  .oc_ref     (oc_ref),
  .oc_o       (oc_o)
);

// File: tb/tb_capchan_ctl.sv
`timescale 1ns/1ps
module tb_capchan_ctl;
  localparam int CNT_W = 16;
  localparam int WDOG  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_pol = 0, wr_npol = 0, wr_oen = 0, wr_noen = 0;
  logic [1:0] lock_lvl = 2'd0;
  logic is_output = 0, preload_on = 0, commute = 0;
  logic sig_in = 0, oc_ref = 0, ocn_ref = 0;
  logic [CNT_W-1:0] cnt_in = '0;
  logic trig_o, gate_o, cap_stb_o, oc_o, ocn_o, pol_o, npol_o, oen_o, noen_o;
  logic [CNT_W-1:0] cap_val_o;

  always #2.5 clk = ~clk;

  capchan_ctl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pol(wr_pol), .wr_npol(wr_npol),
    .wr_oen(wr_oen), .wr_noen(wr_noen), .lock_lvl(lock_lvl),
    .is_output(is_output), .preload_on(preload_on), .commute(commute),
    .sig_in(sig_in), .cnt_in(cnt_in), .oc_ref(oc_ref), .ocn_ref(ocn_ref),
    .trig_o(trig_o), .gate_o(gate_o), .cap_stb_o(cap_stb_o),
    .cap_val_o(cap_val_o), .oc_o(oc_o), .ocn_o(ocn_o), .pol_o(pol_o),
    .npol_o(npol_o), .oen_o(oen_o), .noen_o(noen_o));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  // scoreboard queues
  int          q_cyc[$];
  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  // bench-side configuration
  logic [1:0] b_lock = 0;
  bit b_isout = 0, b_pre = 0;

  // requirement model state
  bit m_pol, m_npol, m_sh_pol, m_sh_npol, m_en, m_nen, m_prev, m_vld;
  logic [CNT_W-1:0] m_cap;

  function automatic string sel_name(int s);
    case (s)
      0: return "trig_o";   1: return "gate_o";  2: return "cap_stb_o";
      3: return "cap_val_o"; 4: return "oc_o";   5: return "ocn_o";
      6: return "pol_o";    7: return "npol_o";  8: return "oen_o";
      default: return "noen_o";
    endcase
  endfunction

  function automatic logic [31:0] actual(int s);
    case (s)
      0: return 32'(trig_o);    1: return 32'(gate_o);
      2: return 32'(cap_stb_o); 3: return 32'(cap_val_o);
      4: return 32'(oc_o);      5: return 32'(ocn_o);
      6: return 32'(pol_o);     7: return 32'(npol_o);
      8: return 32'(oen_o);     default: return 32'(noen_o);
    endcase
  endfunction

  task automatic check(string tag, string nm, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, got, exp);
    end
  endtask

  task automatic push(int c, int s, logic [31:0] e, string tag);
    q_cyc.push_back(c); q_sel.push_back(s); q_exp.push_back(e); q_tag.push_back(tag);
  endtask

  // monitor: compare before the driver changes inputs at this negedge
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      check(q_tag[0], sel_name(q_sel[0]), actual(q_sel[0]), q_exp[0]);
      void'(q_cyc.pop_front()); void'(q_sel.pop_front());
      void'(q_exp.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic model_reset();
    m_pol = 0; m_npol = 0; m_sh_pol = 0; m_sh_npol = 0;
    m_en = 0; m_nen = 0; m_prev = 0; m_vld = 0; m_cap = '0;
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk); #1;
    rst = 1; sig_in = s; wr_en = 0; commute = 0;
    repeat (3) @(negedge clk);
    check("R1", "pol_o", 32'(pol_o), 0);
    check("R1", "npol_o", 32'(npol_o), 0);
    check("R1", "oen_o", 32'(oen_o), 0);
    check("R1", "noen_o", 32'(noen_o), 0);
    check("R1", "cap_val_o", 32'(cap_val_o), 0);
    check("R1", "trig_o", 32'(trig_o), 0);
    check("R1", "oc_o", 32'(oc_o), 0);
    model_reset();
  endtask

  // one cycle of stimulus; expected outputs follow from the model state
  task automatic drive(input bit s, input bit w, input bit wp, input bit wnp,
                       input bit we, input bit wne, input bit cm, input string tag);
    logic [CNT_W-1:0] cv;
    bit ocr, ocnr, r, f, tg, cs, pol_ok, npol_ok;
    bit [1:0] code;
    int c;
    @(negedge clk); #1;
    c = cyc;
    cv = CNT_W'(c * 7 + 3);
    ocr = c[0]; ocnr = c[1];
    rst = 0; sig_in = s; cnt_in = cv; oc_ref = ocr; ocn_ref = ocnr;
    wr_en = w; wr_pol = wp; wr_npol = wnp; wr_oen = we; wr_noen = wne;
    commute = cm; lock_lvl = b_lock; is_output = b_isout; preload_on = b_pre;

    code = {m_npol, m_pol};
    r = m_vld & s & !m_prev;
    f = m_vld & !s & m_prev;
    if (code == 2'b01)      tg = f;
    else if (code == 2'b11) tg = r | f;
    else                    tg = r;
    cs = tg & m_en & !b_isout;
    if (cs) m_cap = cv;
    push(c + 1, 0, 32'(tg), tag);
    push(c + 1, 1, 32'(s ^ (code == 2'b01)), tag);
    push(c + 1, 2, 32'(cs), tag);
    push(c + 1, 3, 32'(m_cap), tag);
    push(c + 1, 4, 32'(ocr ^ m_pol), tag);
    push(c + 1, 5, 32'(ocnr ^ m_npol), tag);

    pol_ok  = w && (b_lock < 2);
    npol_ok = w && !((b_lock >= 2) && b_isout);
    if (b_pre && cm) begin
      m_pol = m_sh_pol; m_npol = m_sh_npol;
    end else if (!b_pre) begin
      if (pol_ok)  m_pol  = wp;
      if (npol_ok) m_npol = wnp;
    end
    if (pol_ok)  m_sh_pol  = wp;
    if (npol_ok) m_sh_npol = wnp;
    if (w) begin m_en = we; m_nen = wne; end
    m_prev = s; m_vld = 1;
    push(c + 1, 6, 32'(m_pol), tag);
    push(c + 1, 7, 32'(m_npol), tag);
    push(c + 1, 8, 32'(m_en), tag);
    push(c + 1, 9, 32'(m_nen), tag);
  endtask

  initial begin
    model_reset();
    do_reset(1);
    // R12: input high across reset must not give an edge
    drive(1, 0,0,0,0,0, 0, "R12");
    drive(1, 0,0,0,0,0, 0, "R12");
    // R2: rising only, code 00, capture disabled
    drive(0, 0,0,0,0,0, 0, "R2");
    drive(1, 0,0,0,0,0, 0, "R2");
    drive(1, 0,0,0,0,0, 0, "R2");
    // R8: direct write of the enable; R6 capture on rise
    drive(0, 1,0,0,1,0, 0, "R8");
    drive(1, 0,0,0,0,0, 0, "R6");
    drive(0, 0,0,0,0,0, 0, "R6");
    drive(0, 1,0,0,0,1, 0, "R6");
    drive(1, 0,0,0,0,0, 0, "R6");       // edge with enable off: no capture
    // R3: falling-edge code 01
    drive(1, 1,1,0,1,0, 0, "R8");
    drive(0, 0,0,0,0,0, 0, "R3");
    drive(1, 0,0,0,0,0, 0, "R3");
    drive(0, 0,0,0,0,0, 0, "R3");
    // R4: both edges
    drive(0, 1,1,1,1,0, 0, "R4");
    drive(1, 0,0,0,0,0, 0, "R4");
    drive(0, 0,0,0,0,0, 0, "R4");
    drive(1, 0,0,0,0,0, 0, "R4");
    // R5: reserved code 10 acts as rising
    drive(1, 1,0,1,1,0, 0, "R5");
    drive(0, 0,0,0,0,0, 0, "R5");
    drive(1, 0,0,0,0,0, 0, "R5");
    // R7: output polarity with both settings
    for (int i = 0; i < 4; i++) drive(1, 0,0,0,0,0, 0, "R7");
    drive(1, 1,1,0,1,1, 0, "R7");
    for (int i = 0; i < 4; i++) drive(1, 0,0,0,0,0, 0, "R7");
    // R9: preload holds active bits until commutation
    b_pre = 1;
    drive(1, 1,0,1,1,1, 0, "R9");
    drive(1, 0,0,0,0,0, 0, "R9");
    drive(1, 0,0,0,0,0, 1, "R9");
    // R10: write and commutation in one cycle
    drive(1, 1,1,0,1,1, 1, "R10");
    drive(1, 0,0,0,0,0, 0, "R10");
    drive(1, 0,0,0,0,0, 1, "R10");
    // R11: lock level
    b_pre = 0; b_lock = 2; b_isout = 0;
    drive(1, 1,0,1,1,0, 0, "R11");
    b_isout = 1;
    drive(1, 1,0,0,1,0, 0, "R11");
    drive(1, 0,0,0,0,0, 0, "R11");
    b_lock = 3;
    drive(1, 1,0,0,1,0, 0, "R11");
    b_lock = 1;
    drive(1, 1,0,0,1,0, 0, "R11");
    b_lock = 0; b_isout = 0;
    drive(1, 1,1,1,1,1, 0, "R8");
    drive(1, 0,0,0,0,0, 0, "R8");
    // R1: reset from a non-zero state
    do_reset(0);
    drive(0, 0,0,0,0,0, 0, "R12");
    drive(1, 0,0,0,0,0, 0, "R2");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(WDOG * 5.0);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule